// File: doc/BRIEF.md
# Miller Encoder Transmit Framer

This block turns a tag response into the on/off pattern of the load-modulation switch. A caller presents a frame type and a data word together with a one-cycle load strobe. The framer then runs the frame out at the carrier rate on a registered modulator-enable line and raises a one-cycle done flag when it has finished. There are three data frame sizes (a 32-bit word, a 96-bit identity frame and a 128-bit page), plus a fixed 4-bit header used during tag arbitration.

A data frame is framed as follows. A start bit of 1 comes first. Each group of eight data bits is followed by an even-parity bit, and the frame closes with a stop bit of 0. The resulting symbol stream is Miller coded at 16 carrier cycles per symbol. Because a 0 changes level at its end only when the following symbol is also 0, the encoder looks one symbol ahead, and that includes the parity bits it inserts itself. The stop bit is cut short to a single carrier cycle. It keeps the level that the last parity bit leaves behind. The header is sent as a fixed level pattern, without framing and without parity.

The framer accepts a load only while it is idle. Any strobe raised during a frame is dropped, and the frame in flight is not disturbed.

Top module: `miller_tx_framer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, mod_en and done are both 0.
- R2: A data frame whose load is sampled at clock edge E0 shows its first carrier cycle on mod_en in the cycle after edge E0+1. That first symbol is the start bit: 8 cycles low, then 8 cycles high.
- R3: A symbol of value 1 lasts 16 cycles. Its level inverts between cycle 7 and cycle 8 of the symbol.
- R4: A symbol of value 0 lasts 16 cycles and holds one level throughout. The level inverts at its end only if the next symbol (data, parity or stop) is also 0.
- R5: Each group of 8 data bits is followed by one parity symbol, chosen so that the group of 9 holds an even number of ones. The start and stop bits take no part in parity.
- R6: frame_kind selects the frame: 0 is the header, 1 is a word taken from data[31:0], 2 is an identity frame taken from data[95:0], and 3 is a page taken from data[127:0]. Bits are sent MSB first, so byte 0 of an identity frame is data[95:88].
- R7: The stop symbol lasts exactly one carrier cycle. Its level is the one carried out of the last parity symbol under R4, treating the stop as a following 0.
- R8: A header (frame_kind 0) is 64 cycles long: 8 cycles low, 48 cycles high, 8 cycles low. It has no start bit, no parity and no stop bit.
- R9: done is high for exactly one cycle, the cycle that follows the frame's last carrier cycle. mod_en is 0 during that cycle and stays 0 until the next frame begins.
- R10: A load strobe that arrives between acceptance and the done cycle is ignored, and the running frame is unchanged. A load raised during the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Start-frame strobe, honoured only when idle |
| frame_kind | input | 2 | Frame type: 0 header, 1 word, 2 identity, 3 page |
| data | input | 128 | Frame payload, right-aligned, MSB sent first |
| mod_en | output | 1 | Registered modulator enable |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Two things can coincide in a single cycle, and the bench is built to force both. The first is the done pulse of one frame and the acceptance of the next: every scenario raises its load in the very cycle that done is seen. The bench then checks that the new frame starts exactly two edges later and that done does not stretch. The second is the look-ahead rule for 0 symbols meeting a parity bit the framer inserts itself. Bytes with even and odd numbers of ones make the last data bit, the parity bit and the short stop bit fall on each possible level combination. Every cycle of mod_en is compared against a symbol-level model that the bench builds from the requirements.

// File: rtl/miller_tx_pkg.sv
package miller_tx_pkg;

  typedef enum logic [1:0] {
    FK_HDR  = 2'd0,
    FK_WORD = 2'd1,
    FK_ID   = 2'd2,
    FK_PAGE = 2'd3
  } frame_kind_e;

  typedef enum logic [2:0] {
    SY_IDLE,
    SY_HDR,
    SY_START,
    SY_DATA,
    SY_PAR,
    SY_STOP,
    SY_DONE
  } sym_e;

  // Level carried into the following symbol.
  function automatic logic miller_carry(input logic lvl, input logic cur, input logic nxt);
    if (cur) return ~lvl;
    return nxt ? lvl : ~lvl;
  endfunction

  // Level shown inside a symbol, first or second half.
  function automatic logic miller_half(input logic lvl, input logic cur, input logic second);
    return (cur && second) ? ~lvl : lvl;
  endfunction

endpackage

// File: rtl/miller_tx_seq.sv
module miller_tx_seq
  import miller_tx_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int WORD_W  = 32,
  parameter int ID_W    = 96,
  parameter int BIT_CYC = 16,
  parameter int HDR_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  frame_kind_e       kind_i,
  input  logic [DATA_W-1:0] data_i,
  output sym_e              sym_o,
  output logic              cur_o,
  output logic              nxt_o,
  output logic [$clog2(HDR_CYC)-1:0] cnt_o,
  output logic              end_o,
  output logic              accept_o
);
  localparam int CNT_W = $clog2(HDR_CYC);
  localparam int LW    = $clog2(DATA_W + 1);

  function automatic logic [LW-1:0] frame_bits(input frame_kind_e k);
    case (k)
      FK_WORD: return LW'(WORD_W);
      FK_ID:   return LW'(ID_W);
      default: return LW'(DATA_W);
    endcase
  endfunction

  sym_e              sym_q, nsym;
  logic              cur_q, nval;
  logic [DATA_W-1:0] sh_q;
  logic [LW-1:0]     left_q, n_load;
  logic [2:0]        pos_q;
  logic              acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sym_end, accept;

  assign accept = load_i && (sym_q == SY_IDLE);
  assign n_load = frame_bits(kind_i);

  // Next symbol and its value: the one-symbol look-ahead.
  always_comb begin
    nsym = SY_IDLE;
    nval = 1'b0;
    case (sym_q)
      SY_START: begin nsym = SY_DATA; nval = sh_q[DATA_W-1]; end
      SY_DATA:
        if (pos_q == 3'd7) begin nsym = SY_PAR; nval = acc_q ^ cur_q; end
        else begin nsym = SY_DATA; nval = sh_q[DATA_W-1]; end
      SY_PAR:
        if (left_q == '0) nsym = SY_STOP;
        else begin nsym = SY_DATA; nval = sh_q[DATA_W-1]; end
      SY_HDR, SY_STOP: nsym = SY_DONE;
      default: nsym = SY_IDLE;
    endcase
  end

  always_comb begin
    case (sym_q)
      SY_HDR:                    sym_end = (cnt_q == CNT_W'(HDR_CYC - 1));
      SY_START, SY_DATA, SY_PAR: sym_end = (cnt_q == CNT_W'(BIT_CYC - 1));
      SY_STOP, SY_DONE:          sym_end = 1'b1;
      default:                   sym_end = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q  <= SY_IDLE;
      cur_q  <= 1'b0;
      sh_q   <= '0;
      left_q <= '0;
      pos_q  <= '0;
      acc_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      cnt_q  <= '0;
      pos_q  <= '0;
      acc_q  <= 1'b0;
      if (kind_i == FK_HDR) begin
        sym_q  <= SY_HDR;
        cur_q  <= 1'b0;
        left_q <= '0;
      end else begin
        sym_q  <= SY_START;
        cur_q  <= 1'b1;
        sh_q   <= data_i << (LW'(DATA_W) - n_load);
        left_q <= n_load;
      end
    end else if (sym_end) begin
      sym_q <= nsym;
      cnt_q <= '0;
      cur_q <= nval;
      if (nsym == SY_DATA) begin
        sh_q   <= sh_q << 1;
        left_q <= left_q - 1'b1;
      end
      if (sym_q == SY_DATA) begin
        pos_q <= pos_q + 3'd1;
        acc_q <= acc_q ^ cur_q;
      end else if (sym_q == SY_PAR) begin
        pos_q <= '0;
        acc_q <= 1'b0;
      end
    end else if (sym_q != SY_IDLE) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sym_o    = sym_q;
  assign cur_o    = cur_q;
  assign nxt_o    = nval;
  assign cnt_o    = cnt_q;
  assign end_o    = sym_end;
  assign accept_o = accept;

endmodule

// File: rtl/miller_tx_line.sv
module miller_tx_line
  import miller_tx_pkg::*;
#(
  parameter int BIT_CYC    = 16,
  parameter int HDR_CYC    = 64,
  parameter int HDR_HALVES = 8,
  parameter logic [HDR_HALVES-1:0] HDR_PAT = 8'b0111_1110
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  sym_e                       sym_i,
  input  logic                       cur_i,
  input  logic                       nxt_i,
  input  logic [$clog2(HDR_CYC)-1:0] cnt_i,
  input  logic                       end_i,
  output logic                       mod_o,
  output logic                       done_o
);
  localparam int CNT_W = $clog2(HDR_CYC);
  localparam int HALF  = BIT_CYC / 2;

  logic             lvl_q, mod_q, done_q, lvl_out, in_bit;
  logic [CNT_W-1:0] hdr_idx;

  assign in_bit  = (sym_i == SY_START) || (sym_i == SY_DATA) || (sym_i == SY_PAR);
  assign hdr_idx = cnt_i / CNT_W'(HALF);

  always_comb begin
    case (sym_i)
      SY_HDR:                    lvl_out = HDR_PAT[HDR_HALVES - 1 - int'(hdr_idx)];
      SY_START, SY_DATA, SY_PAR: lvl_out = miller_half(lvl_q, cur_i, cnt_i >= CNT_W'(HALF));
      SY_STOP:                   lvl_out = lvl_q;
      default:                   lvl_out = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      mod_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      mod_q  <= lvl_out;
      done_q <= (sym_i == SY_DONE);
      if (in_bit && end_i) lvl_q <= miller_carry(lvl_q, cur_i, nxt_i);
      else if (!in_bit && sym_i != SY_STOP) lvl_q <= 1'b0;
    end
  end

  assign mod_o  = mod_q;
  assign done_o = done_q;

endmodule

// File: rtl/miller_tx_framer.sv
module miller_tx_framer
  import miller_tx_pkg::*;
#(
  parameter int DATA_W     = 128,
  parameter int WORD_W     = 32,
  parameter int ID_W       = 96,
  parameter int BIT_CYC    = 16,
  parameter int HDR_HALVES = 8,
  parameter logic [HDR_HALVES-1:0] HDR_PAT = 8'b0111_1110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [1:0]        frame_kind,
  input  logic [DATA_W-1:0] data,
  output logic              mod_en,
  output logic              done
);
  localparam int HDR_CYC = HDR_HALVES * (BIT_CYC / 2);
  localparam int CNT_W   = $clog2(HDR_CYC);

  sym_e             sym_w;
  logic             cur_w, nxt_w, end_w, accept_w, idle_w;
  logic [CNT_W-1:0] cnt_w;

  assign idle_w = (sym_w == SY_IDLE);

  miller_tx_seq #(
    .DATA_W(DATA_W), .WORD_W(WORD_W), .ID_W(ID_W),
    .BIT_CYC(BIT_CYC), .HDR_CYC(HDR_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .load_i(load),
    .kind_i(frame_kind_e'(frame_kind)), .data_i(data),
    .sym_o(sym_w), .cur_o(cur_w), .nxt_o(nxt_w), .cnt_o(cnt_w),
    .end_o(end_w), .accept_o(accept_w)
  );

  miller_tx_line #(
    .BIT_CYC(BIT_CYC), .HDR_CYC(HDR_CYC),
    .HDR_HALVES(HDR_HALVES), .HDR_PAT(HDR_PAT)
  ) u_line (
    .clk(clk), .rst_n(rst_n), .sym_i(sym_w), .cur_i(cur_w), .nxt_i(nxt_w),
    .cnt_i(cnt_w), .end_i(end_w), .mod_o(mod_en), .done_o(done)
  );

endmodule

// File: rtl/miller_tx_framer_chk.sv
module miller_tx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load,
  input logic [1:0] frame_kind,
  input logic       mod_en,
  input logic       done,
  input logic       idle_w
);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mod_en);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle_w |=> !mod_en);

  // First carrier cycle of a data frame is low (start bit, first half).
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && idle_w && frame_kind != 2'd0) |-> ##2 !mod_en);

  p_hdr_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && idle_w && frame_kind == 2'd0) |-> ##2 !mod_en);

  // Ninth carrier cycle is high for both header and start bit.
  p_second_half_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && idle_w) |-> ##10 mod_en);

endmodule

bind miller_tx_framer miller_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .frame_kind(frame_kind),
  .mod_en(mod_en), .done(done), .idle_w(idle_w)
);

// File: tb/test_miller_tx_framer.sv
module test_miller_tx_framer;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [1:0]   kind = 2'd0;
  logic [127:0] data = '0;
  logic         mod_en, done;

  always #10 clk = ~clk;

  miller_tx_framer i_miller_tx_framer (
    .clk(clk), .rst_n(rst_n), .load(load), .frame_kind(kind),
    .data(data), .mod_en(mod_en), .done(done)
  );

  int  tests = 0;
  int  fails = 0;
  bit  finished = 0;
  logic expv [0:2399];
  int  exp_len;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expct);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expct);
    end
  endtask

  // Expected waveform built from the symbol rules.
  task automatic build_expected(input logic [1:0] k, input logic [127:0] d);
    int   n, nb, idx;
    logic b [0:199];
    logic par, lvl;
    if (k == 2'd0) begin
      for (int c = 0; c < 64; c++) expv[c] = (c >= 8 && c < 56);
      exp_len = 64;
      return;
    end
    n = (k == 2'd1) ? 32 : (k == 2'd2) ? 96 : 128;
    nb = 0; par = 1'b0;
    b[nb] = 1'b1; nb++;
    for (int i = 0; i < n; i++) begin
      b[nb] = d[n-1-i]; nb++;
      par = par ^ d[n-1-i];
      if (i % 8 == 7) begin b[nb] = par; nb++; par = 1'b0; end
    end
    lvl = 1'b0; idx = 0;
    for (int s = 0; s < nb; s++) begin
      for (int h = 0; h < 16; h++) begin
        if (h == 8 && b[s]) lvl = ~lvl;
        expv[idx] = lvl; idx++;
      end
      if (!b[s] && (s + 1 == nb || !b[s+1])) lvl = ~lvl;
    end
    expv[idx] = lvl; idx++;
    exp_len = idx;
  endtask

  // Drives one frame, compares every cycle, returns in the done cycle.
  task automatic run_frame(input logic [1:0] k, input logic [127:0] d,
                           input string req, input int inj_at);
    int bad_start, bad_body, bad_stop, bad_done, first_bad;
    logic got;
    build_expected(k, d);
    bad_start = 0; bad_body = 0; bad_stop = 0; bad_done = 0; first_bad = -1;
    load = 1'b1; kind = k; data = d;
    @(negedge clk);
    load = 1'b0;
    for (int c = 0; c < exp_len; c++) begin
      @(negedge clk);
      if (load) load = 1'b0;
      got = mod_en;
      if (done) bad_done++;
      if (k != 2'd0 && c < 16) begin
        if (got !== (c >= 8)) bad_start++;
      end else if (k != 2'd0 && c == exp_len - 1) begin
        if (got !== expv[c]) bad_stop++;
      end else if (got !== expv[c]) begin
        bad_body++;
        if (first_bad < 0) first_bad = c;
      end
      if (c == inj_at) begin
        load = 1'b1; kind = 2'd0; data = ~d;
      end
    end
    @(negedge clk);
    if (load) load = 1'b0;
    if (k != 2'd0) begin
      check(bad_start == 0, "R2", "start bit cycles wrong", bad_start, 0);
      check(bad_stop == 0, "R7", "stop cycle level wrong", bad_stop, 0);
    end
    check(bad_body == 0, req, $sformatf("waveform mismatches (first at cycle %0d)", first_bad),
          bad_body, 0);
    check(bad_done == 0, "R9", "done during frame", bad_done, 0);
    check(done === 1'b1, "R9", "done after last cycle", int'(done), 1);
    check(mod_en === 1'b0, "R9", "mod_en in done cycle", int'(mod_en), 0);
  endtask

  task automatic idle_gap(input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mod_en !== 1'b0 || done !== 1'b0) bad++;
    end
    check(bad == 0, "R10", "activity while idle after ignored loads", bad, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(mod_en === 1'b0 && done === 1'b0, "R1", "outputs in reset", int'({mod_en, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mod_en === 1'b0 && done === 1'b0, "R1", "outputs after reset", int'({mod_en, done}), 0);
  endtask

  task automatic t_ones;   run_frame(2'd1, 128'hFFFF_FFFF, "R3", -1); endtask
  task automatic t_zeros;  run_frame(2'd1, 128'h0, "R4", -1); endtask
  task automatic t_parity; run_frame(2'd1, 128'h0180_7FA5, "R5", -1);
                           run_frame(2'd1, 128'h0000_0001, "R7", -1); endtask

  task automatic t_id;
    logic [127:0] d = '0;
    for (int i = 0; i < 12; i++) d[95 - 8*i -: 8] = 8'(i * 37 + 3);
    d[127:96] = 32'hDEAD_BEEF;
    run_frame(2'd2, d, "R6", -1);
  endtask

  task automatic t_page;
    run_frame(2'd3, 128'h8000_0000_1234_5678_9ABC_DEF0_0F0F_F001, "R6", -1);
  endtask

  task automatic t_header; run_frame(2'd0, 128'hFFFF, "R8", -1); endtask

  task automatic t_busy;
    run_frame(2'd3, 128'h5555_AAAA_0000_FFFF_1357_9BDF_2468_ACE0, "R10", 300);
    run_frame(2'd1, 128'hC3C3_3C3C, "R10", 32 * 16 + 16);
    idle_gap(200);
  endtask

  task automatic t_chain;
    run_frame(2'd0, 128'h0, "R9", -1);
    run_frame(2'd1, 128'hA5A5_5A5A, "R9", -1);
    run_frame(2'd0, 128'h0, "R9", -1);
    run_frame(2'd2, {32'h0, 96'hFFFF_0000_8001_7FFE_0102_0408}, "R4", -1);
  endtask

  initial begin
    t_reset();
    t_ones();
    t_zeros();
    t_parity();
    t_id();
    t_page();
    t_header();
    t_chain();
    t_busy();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule